// File: doc/BRIEF.md
# DVFS Voltage Rail Sequencer

This block carries out the supply side of a processor frequency change. Three rails are involved: a memory rail, a digital logic rail and a per-core rail, where the per-core rail has both a voltage level and a current budget. Software, or a clock controller, issues a raise command before it changes the clock and a lower command after the clock has settled. In each phase the block walks the four rail settings in a fixed order. It writes a setting only when the new target moves in that phase's direction. It waits for the regulator to accept or reject each write and keeps the value that was last accepted.

The targets come from the frequency tables and are partly derived here. The digital-rail target is the largest of three values: the L2 table's own need, the need of the L2 clock source and the need of the CPU clock source. A source's need is set by which PLL multiplier tier it runs in. The core voltage target is the table value, plus a boost offset when boost is enabled. A separate merge unit keeps the latest L2 speed vote of every core and reports the highest vote among the cores that are present.

A reason code qualifies each command: normal, hotplug, power collapse or idle. On hotplug the core voltage step is skipped. Power collapse and idle leave every rail alone.

Top module: `dvfs_rail_sequencer`

## Requirements
- R1: In a raise phase the settings are visited in the order memory (rail_sel 0), digital (1), core current (2), core voltage (3). A write is issued only when the target is strictly above the stored value.
- R2: In a lower phase the order is core voltage (3), core current (2), digital (1), memory (0). A write is issued only when the target is strictly below the stored value.
- R3: With reason 1 (hotplug), the core voltage setting (rail_sel 3) is never written in either phase. The other three settings behave as under reason 0 (normal).
- R4: With reason 2 (power collapse) or 3 (idle), a phase writes no rail and still ends with a done pulse.
- R5: rail_wr_o stays high, with rail_sel_o and rail_val_o unchanged, until rail_ack_i or rail_nack_i. A stored value (cur_*_o) changes only on the cycle its write is acknowledged, and it then takes the written value.
- R6: A nack ends the phase at once. No later step is written, err_o is set and done_o pulses. After a failed raise, lower commands are ignored until the next raise command. A new accepted command clears err_o.
- R7: A clock source's digital need is DIG_NONE (default 50) when it does not run from the PLL. When it does, the need is DIG_HIGH (400) for a multiplier above NOM_L_MAX (40), DIG_NOM (300) for a multiplier above LOW_L_MAX (20), and DIG_LOW (200) otherwise.
- R8: The digital target is the maximum of l2_dig_i, the L2 source need and the CPU source need.
- R9: The core voltage target is core_base_i + boost_i when boost_en_i is 1, and core_base_i when it is 0, modulo 2^VW.
- R10: l2_level_o is the maximum of the latest votes of the cores whose core_present_i bit is 1, or 0 when no core is present. It follows a vote write or a mask change by one register stage, and all votes reset to 0.
- R11: After reset, the write strobe, busy, done, err, all stored values and l2_level_o are 0. Commands that arrive while busy_o is 1 are ignored, and done_o is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_raise_i | input | 1 | Start a raise phase (wins over lower) |
| cmd_lower_i | input | 1 | Start a lower phase |
| reason_i | input | 2 | 0 normal, 1 hotplug, 2 power collapse, 3 idle |
| tgt_mem_i | input | VW | Memory rail target |
| tgt_ua_i | input | VW | Core current target |
| core_base_i | input | VW | Core voltage table value |
| boost_en_i | input | 1 | Add boost offset to core voltage |
| boost_i | input | VW | Boost offset |
| l2_dig_i | input | VW | L2 table digital need |
| l2_pll_i | input | 1 | L2 clock runs from its PLL |
| l2_mult_i | input | LW | L2 PLL multiplier |
| cpu_pll_i | input | 1 | CPU clock runs from its PLL |
| cpu_mult_i | input | LW | CPU PLL multiplier |
| rail_ack_i | input | 1 | Regulator accepted the pending write |
| rail_nack_i | input | 1 | Regulator rejected the pending write |
| rail_wr_o | output | 1 | Write pending |
| rail_sel_o | output | 2 | Setting being written (0 mem, 1 dig, 2 core current, 3 core voltage) |
| rail_val_o | output | VW | Value being written |
| cur_mem_o | output | VW | Stored memory voltage |
| cur_dig_o | output | VW | Stored digital voltage |
| cur_ua_o | output | VW | Stored core current |
| cur_core_o | output | VW | Stored core voltage |
| busy_o | output | 1 | Phase in progress |
| done_o | output | 1 | One-cycle end-of-phase pulse |
| err_o | output | 1 | Last phase ended on a nack |
| vote_we_i | input | 1 | Record an L2 vote |
| vote_core_i | input | $clog2(NCORES) | Voting core |
| vote_lvl_i | input | LVLW | Voted L2 level |
| core_present_i | input | NCORES | Present-core mask |
| l2_level_o | output | LVLW | Applied L2 level |

## Verification
A command is sampled on one edge and the first step is evaluated on the next, so a write appears on rail_wr_o two edges after the command. Every step that is skipped costs one cycle. An acknowledge updates the stored value on the edge where it is sampled. The bench answers writes from a responder process with a delay it can vary, logs every write, and compares the log and the stored values only after done_o has been seen. That timing is therefore never assumed, and its latency is covered by a bounded poll. The L2 level is sampled at the falling edge two clock edges after a vote write or a mask change, which clears the one register stage in the merge unit.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  typedef enum logic [1:0] {
    RSN_NORMAL  = 2'd0,
    RSN_HOTPLUG = 2'd1,
    RSN_PWRCOL  = 2'd2,
    RSN_IDLE    = 2'd3
  } reason_e;

  typedef enum logic [1:0] {
    RAIL_MEM  = 2'd0,
    RAIL_DIG  = 2'd1,
    RAIL_CUR  = 2'd2,
    RAIL_CORE = 2'd3
  } rail_e;

  localparam int NUM_SETTINGS = 4;
endpackage

// File: rtl/pll_dig_need.sv
// Digital-rail requirement of one clock source, from its PLL multiplier tier.
module pll_dig_need #(
  parameter int VW        = 12,
  parameter int LW        = 6,
  parameter int LOW_L_MAX = 20,
  parameter int NOM_L_MAX = 40,
  parameter int DIG_NONE  = 50,
  parameter int DIG_LOW   = 200,
  parameter int DIG_NOM   = 300,
  parameter int DIG_HIGH  = 400
) (
  input  logic          is_pll_i,
  input  logic [LW-1:0] mult_i,
  output logic [VW-1:0] need_o
);
  localparam logic [LW-1:0] LOW_LIM = LW'(LOW_L_MAX);
  localparam logic [LW-1:0] NOM_LIM = LW'(NOM_L_MAX);

  always_comb begin
    if (!is_pll_i)             need_o = VW'(DIG_NONE);
    else if (mult_i > NOM_LIM) need_o = VW'(DIG_HIGH);
    else if (mult_i > LOW_LIM) need_o = VW'(DIG_NOM);
    else                       need_o = VW'(DIG_LOW);
  end
endmodule

// File: rtl/dvfs_target_calc.sv
// Builds the four setting targets from table inputs.
module dvfs_target_calc #(
  parameter int VW        = 12,
  parameter int LW        = 6,
  parameter int LOW_L_MAX = 20,
  parameter int NOM_L_MAX = 40,
  parameter int DIG_NONE  = 50,
  parameter int DIG_LOW   = 200,
  parameter int DIG_NOM   = 300,
  parameter int DIG_HIGH  = 400
) (
  input  logic                tgt_mem_i,
  input  logic [VW-1:0]       mem_i,
  input  logic [VW-1:0]       ua_i,
  input  logic [VW-1:0]       core_base_i,
  input  logic                boost_en_i,
  input  logic [VW-1:0]       boost_i,
  input  logic [VW-1:0]       l2_dig_i,
  input  logic                l2_pll_i,
  input  logic [LW-1:0]       l2_mult_i,
  input  logic                cpu_pll_i,
  input  logic [LW-1:0]       cpu_mult_i,
  output logic [3:0][VW-1:0]  tgt_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0]          src_pll;
  logic [NSRC-1:0][LW-1:0]  src_mult;
  logic [NSRC-1:0][VW-1:0]  src_need;
  logic [VW-1:0]            dig_max;

  assign src_pll  = {cpu_pll_i, l2_pll_i};
  assign src_mult = {cpu_mult_i, l2_mult_i};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    pll_dig_need #(
      .VW(VW), .LW(LW), .LOW_L_MAX(LOW_L_MAX), .NOM_L_MAX(NOM_L_MAX),
      .DIG_NONE(DIG_NONE), .DIG_LOW(DIG_LOW), .DIG_NOM(DIG_NOM), .DIG_HIGH(DIG_HIGH)
    ) u_need (
      .is_pll_i(src_pll[g]),
      .mult_i  (src_mult[g]),
      .need_o  (src_need[g])
    );
  end

  always_comb begin
    dig_max = l2_dig_i;
    for (int i = 0; i < NSRC; i++)
      if (src_need[i] > dig_max) dig_max = src_need[i];
  end

  always_comb begin
    tgt_o[0] = mem_i;
    tgt_o[1] = dig_max;
    tgt_o[2] = ua_i;
    tgt_o[3] = boost_en_i ? core_base_i + boost_i : core_base_i;
  end

  logic unused_sel;
  assign unused_sel = tgt_mem_i;
endmodule

// File: rtl/l2_vote_merge.sv
// Keeps each core's latest L2 vote and registers the maximum over present cores.
module l2_vote_merge #(
  parameter int NCORES = 4,
  parameter int LVLW   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      vote_we_i,
  input  logic [$clog2(NCORES)-1:0] vote_core_i,
  input  logic [LVLW-1:0]           vote_lvl_i,
  input  logic [NCORES-1:0]         present_i,
  output logic [LVLW-1:0]           level_o
);
  logic [NCORES-1:0][LVLW-1:0] votes_q;
  logic [LVLW-1:0]             max_c;

  for (genvar c = 0; c < NCORES; c++) begin : g_vote
    always_ff @(posedge clk) begin
      if (rst)
        votes_q[c] <= '0;
      else if (vote_we_i && vote_core_i == c)
        votes_q[c] <= vote_lvl_i;
    end
  end

  always_comb begin
    max_c = '0;
    for (int c = 0; c < NCORES; c++)
      if (present_i[c] && votes_q[c] > max_c) max_c = votes_q[c];
  end

  always_ff @(posedge clk) begin
    if (rst) level_o <= '0;
    else     level_o <= max_c;
  end
endmodule

// File: rtl/rail_step_fsm.sv
// Walks the four settings in phase order and runs the write handshake.
module rail_step_fsm
  import dvfs_pkg::*;
#(
  parameter int VW = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_raise_i,
  input  logic               cmd_lower_i,
  input  logic [1:0]         reason_i,
  input  logic [3:0][VW-1:0] tgt_i,
  input  logic               ack_i,
  input  logic               nack_i,
  output logic               wr_o,
  output logic [1:0]         sel_o,
  output logic [VW-1:0]      val_o,
  output logic [3:0][VW-1:0] cur_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic               act_raise_o,
  output logic [1:0]         act_reason_o
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WAIT} st_e;

  st_e                state_q;
  logic [1:0]         idx_q;
  logic               raise_q;
  reason_e            reason_q;
  logic               blocked_q;
  logic [3:0][VW-1:0] tgt_q;
  logic [3:0][VW-1:0] cur_q;

  rail_e         step_sel;
  logic [VW-1:0] step_tgt;
  logic [VW-1:0] step_cur;
  logic          step_allowed;
  logic          step_need;
  logic          accept;

  always_comb begin
    step_sel     = raise_q ? rail_e'(idx_q) : rail_e'(2'd3 - idx_q);
    step_tgt     = tgt_q[step_sel];
    step_cur     = cur_q[step_sel];
    step_allowed = (reason_q == RSN_NORMAL) ||
                   (reason_q == RSN_HOTPLUG && step_sel != RAIL_CORE);
    step_need    = step_allowed && (raise_q ? (step_tgt > step_cur)
                                            : (step_tgt < step_cur));
    accept       = cmd_raise_i || (cmd_lower_i && !blocked_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      idx_q     <= '0;
      raise_q   <= 1'b0;
      reason_q  <= RSN_NORMAL;
      blocked_q <= 1'b0;
      tgt_q     <= '0;
      cur_q     <= '0;
      wr_o      <= 1'b0;
      sel_o     <= '0;
      val_o     <= '0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            raise_q  <= cmd_raise_i;
            reason_q <= reason_e'(reason_i);
            tgt_q    <= tgt_i;
            idx_q    <= '0;
            err_o    <= 1'b0;
            state_q  <= S_EVAL;
            if (cmd_raise_i) blocked_q <= 1'b0;
          end
        end
        S_EVAL: begin
          if (step_need) begin
            wr_o    <= 1'b1;
            sel_o   <= step_sel;
            val_o   <= step_tgt;
            state_q <= S_WAIT;
          end else if (idx_q == 2'd3) begin
            done_o  <= 1'b1;
            state_q <= S_IDLE;
          end else begin
            idx_q <= idx_q + 2'd1;
          end
        end
        S_WAIT: begin
          if (ack_i) begin
            wr_o         <= 1'b0;
            cur_q[sel_o] <= val_o;
            if (idx_q == 2'd3) begin
              done_o  <= 1'b1;
              state_q <= S_IDLE;
            end else begin
              idx_q   <= idx_q + 2'd1;
              state_q <= S_EVAL;
            end
          end else if (nack_i) begin
            wr_o      <= 1'b0;
            err_o     <= 1'b1;
            blocked_q <= raise_q;
            done_o    <= 1'b1;
            state_q   <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cur_o        = cur_q;
  assign busy_o       = (state_q != S_IDLE);
  assign act_raise_o  = raise_q;
  assign act_reason_o = reason_q;
endmodule

// File: rtl/dvfs_rail_sequencer.sv
module dvfs_rail_sequencer #(
  parameter int VW        = 12,
  parameter int LW        = 6,
  parameter int NCORES    = 4,
  parameter int LVLW      = 3,
  parameter int LOW_L_MAX = 20,
  parameter int NOM_L_MAX = 40,
  parameter int DIG_NONE  = 50,
  parameter int DIG_LOW   = 200,
  parameter int DIG_NOM   = 300,
  parameter int DIG_HIGH  = 400
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cmd_raise_i,
  input  logic                      cmd_lower_i,
  input  logic [1:0]                reason_i,
  input  logic [VW-1:0]             tgt_mem_i,
  input  logic [VW-1:0]             tgt_ua_i,
  input  logic [VW-1:0]             core_base_i,
  input  logic                      boost_en_i,
  input  logic [VW-1:0]             boost_i,
  input  logic [VW-1:0]             l2_dig_i,
  input  logic                      l2_pll_i,
  input  logic [LW-1:0]             l2_mult_i,
  input  logic                      cpu_pll_i,
  input  logic [LW-1:0]             cpu_mult_i,
  input  logic                      rail_ack_i,
  input  logic                      rail_nack_i,
  output logic                      rail_wr_o,
  output logic [1:0]                rail_sel_o,
  output logic [VW-1:0]             rail_val_o,
  output logic [VW-1:0]             cur_mem_o,
  output logic [VW-1:0]             cur_dig_o,
  output logic [VW-1:0]             cur_ua_o,
  output logic [VW-1:0]             cur_core_o,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      err_o,
  input  logic                      vote_we_i,
  input  logic [$clog2(NCORES)-1:0] vote_core_i,
  input  logic [LVLW-1:0]           vote_lvl_i,
  input  logic [NCORES-1:0]         core_present_i,
  output logic [LVLW-1:0]           l2_level_o
);
  logic [3:0][VW-1:0] tgt_w;
  logic [3:0][VW-1:0] cur_w;
  logic               act_raise;
  logic [1:0]         act_reason;

  dvfs_target_calc #(
    .VW(VW), .LW(LW), .LOW_L_MAX(LOW_L_MAX), .NOM_L_MAX(NOM_L_MAX),
    .DIG_NONE(DIG_NONE), .DIG_LOW(DIG_LOW), .DIG_NOM(DIG_NOM), .DIG_HIGH(DIG_HIGH)
  ) u_calc (
    .tgt_mem_i  (1'b0),
    .mem_i      (tgt_mem_i),
    .ua_i       (tgt_ua_i),
    .core_base_i(core_base_i),
    .boost_en_i (boost_en_i),
    .boost_i    (boost_i),
    .l2_dig_i   (l2_dig_i),
    .l2_pll_i   (l2_pll_i),
    .l2_mult_i  (l2_mult_i),
    .cpu_pll_i  (cpu_pll_i),
    .cpu_mult_i (cpu_mult_i),
    .tgt_o      (tgt_w)
  );

  rail_step_fsm #(.VW(VW)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .cmd_raise_i (cmd_raise_i),
    .cmd_lower_i (cmd_lower_i),
    .reason_i    (reason_i),
    .tgt_i       (tgt_w),
    .ack_i       (rail_ack_i),
    .nack_i      (rail_nack_i),
    .wr_o        (rail_wr_o),
    .sel_o       (rail_sel_o),
    .val_o       (rail_val_o),
    .cur_o       (cur_w),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .err_o       (err_o),
    .act_raise_o (act_raise),
    .act_reason_o(act_reason)
  );

  l2_vote_merge #(.NCORES(NCORES), .LVLW(LVLW)) u_vote (
    .clk        (clk),
    .rst        (rst),
    .vote_we_i  (vote_we_i),
    .vote_core_i(vote_core_i),
    .vote_lvl_i (vote_lvl_i),
    .present_i  (core_present_i),
    .level_o    (l2_level_o)
  );

  assign cur_mem_o  = cur_w[0];
  assign cur_dig_o  = cur_w[1];
  assign cur_ua_o   = cur_w[2];
  assign cur_core_o = cur_w[3];
endmodule

// File: rtl/dvfs_rail_sequencer_chk.sv
module dvfs_rail_sequencer_chk #(
  parameter int VW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          rail_ack_i,
  input logic          rail_nack_i,
  input logic          rail_wr_o,
  input logic [1:0]    rail_sel_o,
  input logic [VW-1:0] rail_val_o,
  input logic [VW-1:0] cur_mem_o,
  input logic [VW-1:0] cur_dig_o,
  input logic [VW-1:0] cur_ua_o,
  input logic [VW-1:0] cur_core_o,
  input logic          done_o,
  input logic          act_raise,
  input logic [1:0]    act_reason
);
  logic [VW-1:0] cur_of_sel;
  always_comb begin
    case (rail_sel_o)
      2'd0:    cur_of_sel = cur_mem_o;
      2'd1:    cur_of_sel = cur_dig_o;
      2'd2:    cur_of_sel = cur_ua_o;
      default: cur_of_sel = cur_core_o;
    endcase
  end

  assert_raise_goes_up_R1: assert property (@(posedge clk) disable iff (rst)
    (rail_wr_o && act_raise) |-> (rail_val_o > cur_of_sel));

  assert_lower_goes_down_R2: assert property (@(posedge clk) disable iff (rst)
    (rail_wr_o && !act_raise) |-> (rail_val_o < cur_of_sel));

  assert_no_core_v_on_hotplug_R3: assert property (@(posedge clk) disable iff (rst)
    (rail_wr_o && act_reason == 2'd1) |-> (rail_sel_o != 2'd3));

  assert_quiet_reasons_R4: assert property (@(posedge clk) disable iff (rst)
    rail_wr_o |-> (act_reason == 2'd0 || act_reason == 2'd1));

  assert_hold_until_resp_R5: assert property (@(posedge clk) disable iff (rst)
    (rail_wr_o && !rail_ack_i && !rail_nack_i) |=>
      (rail_wr_o && $stable(rail_sel_o) && $stable(rail_val_o)));

  assert_store_only_on_ack_R5: assert property (@(posedge clk) disable iff (rst)
    !rail_ack_i |=> ($stable(cur_mem_o) && $stable(cur_dig_o) &&
                     $stable(cur_ua_o) && $stable(cur_core_o)));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

bind dvfs_rail_sequencer dvfs_rail_sequencer_chk #(.VW(VW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .rail_ack_i (rail_ack_i),
  .rail_nack_i(rail_nack_i),
  .rail_wr_o  (rail_wr_o),
  .rail_sel_o (rail_sel_o),
  .rail_val_o (rail_val_o),
  .cur_mem_o  (cur_mem_o),
  .cur_dig_o  (cur_dig_o),
  .cur_ua_o   (cur_ua_o),
  .cur_core_o (cur_core_o),
  .done_o     (done_o),
  .act_raise  (act_raise),
  .act_reason (act_reason)
);

// File: tb/dvfs_rail_sequencer_tb.sv
module dvfs_rail_sequencer_tb;
  localparam int VW = 12;
  localparam int LW = 6;
  localparam int NC = 4;
  localparam int LV = 3;

  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  logic          cmd_raise = 0, cmd_lower = 0;
  logic [1:0]    reason = 0;
  logic [VW-1:0] tgt_mem = 0, tgt_ua = 0, core_base = 0, boost = 0, l2_dig = 0;
  logic          boost_en = 0, l2_pll = 0, cpu_pll = 0;
  logic [LW-1:0] l2_mult = 0, cpu_mult = 0;
  logic          rail_ack = 0, rail_nack = 0;
  logic          rail_wr;
  logic [1:0]    rail_sel;
  logic [VW-1:0] rail_val, cur_mem, cur_dig, cur_ua, cur_core;
  logic          busy, done, err;
  logic          vote_we = 0;
  logic [1:0]    vote_core = 0;
  logic [LV-1:0] vote_lvl = 0;
  logic [NC-1:0] present = 0;
  logic [LV-1:0] l2_level;

  dvfs_rail_sequencer #(.VW(VW), .LW(LW), .NCORES(NC), .LVLW(LV)) u_dut (
    .clk(clk), .rst(rst), .cmd_raise_i(cmd_raise), .cmd_lower_i(cmd_lower),
    .reason_i(reason), .tgt_mem_i(tgt_mem), .tgt_ua_i(tgt_ua),
    .core_base_i(core_base), .boost_en_i(boost_en), .boost_i(boost),
    .l2_dig_i(l2_dig), .l2_pll_i(l2_pll), .l2_mult_i(l2_mult),
    .cpu_pll_i(cpu_pll), .cpu_mult_i(cpu_mult),
    .rail_ack_i(rail_ack), .rail_nack_i(rail_nack),
    .rail_wr_o(rail_wr), .rail_sel_o(rail_sel), .rail_val_o(rail_val),
    .cur_mem_o(cur_mem), .cur_dig_o(cur_dig), .cur_ua_o(cur_ua), .cur_core_o(cur_core),
    .busy_o(busy), .done_o(done), .err_o(err),
    .vote_we_i(vote_we), .vote_core_i(vote_core), .vote_lvl_i(vote_lvl),
    .core_present_i(present), .l2_level_o(l2_level)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Regulator responder: logs every write, answers after resp_dly cycles.
  int resp_dly = 0;
  int fail_sel = -1;
  int wr_cnt = 0;
  int log_sel[8];
  int log_val[8];
  int hold = 0;
  initial begin
    forever begin
      @(negedge clk);
      rail_ack = 0;
      rail_nack = 0;
      if (rail_wr) begin
        if (hold == 0 && wr_cnt < 8) begin
          log_sel[wr_cnt] = int'(rail_sel);
          log_val[wr_cnt] = int'(rail_val);
          wr_cnt++;
        end
        if (hold >= resp_dly) begin
          if (int'(rail_sel) == fail_sel) rail_nack = 1;
          else rail_ack = 1;
          hold = 0;
        end else hold++;
      end
    end
  end

  // Bench model of stored values and of the lower-blocked condition.
  int m[4];
  bit m_blocked = 0;

  function automatic int need_of(input bit pll, input int mult);
    if (!pll) return 50;
    if (mult > 40) return 400;
    if (mult > 20) return 300;
    return 200;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int r = a;
    if (b > r) r = b;
    if (c > r) r = c;
    return r;
  endfunction

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int k = 0; k < 80 && !seen; k++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    check(seen, {tag, " done"}, seen, 1);
  endtask

  // Runs one phase and compares write log, stored values and error flag.
  task automatic do_phase(input bit raise, input int rsn, input int fsel,
                          input bit poke, input string tag);
    int t[4];
    int esel[4];
    int evl[4];
    int ecnt = 0;
    bit eerr = 0;
    t[0] = int'(tgt_mem);
    t[1] = max3(int'(l2_dig), need_of(l2_pll, int'(l2_mult)), need_of(cpu_pll, int'(cpu_mult)));
    t[2] = int'(tgt_ua);
    t[3] = (int'(core_base) + (boost_en ? int'(boost) : 0)) % 4096;
    for (int i = 0; i < 4; i++) begin
      int s;
      s = raise ? i : 3 - i;
      if (!eerr && (rsn == 0 || (rsn == 1 && s != 3)) &&
          (raise ? (t[s] > m[s]) : (t[s] < m[s]))) begin
        esel[ecnt] = s;
        evl[ecnt] = t[s];
        ecnt++;
        if (s == fsel) eerr = 1;
        else m[s] = t[s];
      end
    end
    fail_sel = fsel;
    wr_cnt = 0;
    reason = 2'(rsn);
    @(negedge clk);
    if (raise) cmd_raise = 1; else cmd_lower = 1;
    @(negedge clk);
    cmd_raise = 0;
    cmd_lower = 0;
    if (poke) begin
      cmd_lower = 1; cmd_raise = 1;
      @(negedge clk);
      cmd_lower = 0; cmd_raise = 0;
    end
    wait_done(tag);
    check(wr_cnt == ecnt, {tag, " write count"}, wr_cnt, ecnt);
    for (int i = 0; i < ecnt && i < wr_cnt; i++) begin
      check(log_sel[i] == esel[i], {tag, " write order"}, log_sel[i], esel[i]);
      check(log_val[i] == evl[i], {tag, " write value"}, log_val[i], evl[i]);
    end
    check(int'(cur_mem) == m[0], {tag, " R5 cur_mem"}, int'(cur_mem), m[0]);
    check(int'(cur_dig) == m[1], {tag, " R5 cur_dig"}, int'(cur_dig), m[1]);
    check(int'(cur_ua) == m[2], {tag, " R5 cur_ua"}, int'(cur_ua), m[2]);
    check(int'(cur_core) == m[3], {tag, " R5 cur_core"}, int'(cur_core), m[3]);
    check(err == eerr, {tag, " R6 err"}, err, eerr);
    if (eerr && raise) m_blocked = 1;
    if (raise) m_blocked = eerr;
    if (poke) begin
      repeat (5) @(negedge clk);
      check(!busy && wr_cnt == ecnt, {tag, " R11 command while busy ignored"}, wr_cnt, ecnt);
    end
    fail_sel = -1;
  endtask

  task automatic set_core_tgt(input int v, input bit ben);
    boost_en = ben;
    boost = 12'd15;
    core_base = ben ? 12'(v - 15) : 12'(v);
  endtask

  task automatic hold_targets();
    tgt_mem = 12'(m[0]);
    l2_dig = 12'(m[1]);
    l2_pll = 0; cpu_pll = 0;
    tgt_ua = 12'(m[2]);
    set_core_tgt(m[3], 0);
  endtask

  int vm[4];

  task automatic check_level(input string tag);
    int e = 0;
    for (int c = 0; c < 4; c++) if (present[c] && vm[c] > e) e = vm[c];
    check(int'(l2_level) == e, tag, int'(l2_level), e);
  endtask

  task automatic vote(input int c, input int l);
    @(negedge clk);
    vote_we = 1; vote_core = 2'(c); vote_lvl = 3'(l);
    @(negedge clk);
    vote_we = 0;
    vm[c] = l;
    @(negedge clk);
    check_level("R10 level after vote");
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin m[i] = 0; vm[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    check(!rail_wr && !busy && !done && !err, "R11 reset strobes", {rail_wr, busy, done, err}, 0);
    check(cur_mem == 0 && cur_dig == 0 && cur_ua == 0 && cur_core == 0, "R11 reset stored",
          int'(cur_mem) + int'(cur_dig) + int'(cur_ua) + int'(cur_core), 0);
    check(l2_level == 0, "R11 reset level", int'(l2_level), 0);

    // Initial raise to a known point (R1)
    tgt_mem = 100; l2_dig = 100; tgt_ua = 100; set_core_tgt(100, 0);
    do_phase(1, 0, -1, 0, "R1 initial raise");

    // Near-exhaustive sweep over above/equal/below for every setting (R1 R2 R3 R9)
    for (int code = 0; code < 81; code++) begin
      int d[4];
      int rsn;
      d[0] = code % 3; d[1] = (code / 3) % 3; d[2] = (code / 9) % 3; d[3] = (code / 27) % 3;
      rsn = (code / 2) % 2;
      resp_dly = code % 3;
      tgt_mem = 12'(80 + 20 * d[0]); l2_dig = 12'(80 + 20 * d[1]);
      l2_pll = 0; cpu_pll = 0;
      tgt_ua = 12'(80 + 20 * d[2]); set_core_tgt(80 + 20 * d[3], code[0]);
      do_phase(1, rsn, -1, 0, rsn == 1 ? "R3 hotplug raise" : "R1 raise sweep");
      tgt_mem = 12'(120 - 20 * d[0]); l2_dig = 12'(120 - 20 * d[1]);
      tgt_ua = 12'(120 - 20 * d[2]); set_core_tgt(120 - 20 * d[3], !code[0]);
      do_phase(0, rsn, -1, 0, rsn == 1 ? "R3 hotplug lower" : "R2 lower sweep R9");
    end
    resp_dly = 0;

    // R4 power collapse and idle: no writes
    tgt_mem = 900; l2_dig = 900; tgt_ua = 900; set_core_tgt(900, 1);
    do_phase(1, 2, -1, 0, "R4 power-collapse raise");
    do_phase(1, 3, -1, 0, "R4 idle raise");
    tgt_mem = 1; l2_dig = 1; tgt_ua = 1; set_core_tgt(1, 0);
    do_phase(0, 2, -1, 0, "R4 power-collapse lower");
    do_phase(0, 3, -1, 0, "R4 idle lower");

    // R7 R8: digital target from PLL tiers, observed through a lower write
    for (int k = 0; k < 3 * 64; k++) begin
      int mult = k % 64;
      int mode = k / 64;
      hold_targets();
      l2_dig = 4000;
      do_phase(1, 0, -1, 0, "R8 dig preset");
      hold_targets();
      l2_dig = (mode == 2) ? 12'(250) : 12'(0);
      l2_pll = (mode != 1) ? 1'b0 : 1'b1;
      cpu_pll = (mode != 1) ? 1'b1 : 1'b0;
      l2_mult = 6'(mult);
      cpu_mult = 6'(mult);
      if (mode == 2) l2_pll = 1'b0;
      do_phase(0, 0, -1, 0, mode == 2 ? "R8 dig max of table and sources" : "R7 dig tier");
    end

    // R11 commands while busy are ignored
    resp_dly = 4;
    hold_targets(); tgt_mem = 12'(m[0] + 30); tgt_ua = 12'(m[2] + 30);
    do_phase(1, 0, -1, 1, "R11 busy raise");
    resp_dly = 0;

    // R6 failed raise blocks lower until next raise
    hold_targets(); tgt_mem = 12'(m[0] + 10); l2_dig = 12'(m[1] + 10);
    do_phase(1, 0, 0, 0, "R6 raise nack on memory");
    hold_targets(); tgt_mem = 12'(m[0] - 5);
    wr_cnt = 0;
    @(negedge clk); cmd_lower = 1; @(negedge clk); cmd_lower = 0;
    repeat (12) @(negedge clk);
    check(wr_cnt == 0 && !busy, "R6 lower ignored after failed raise", wr_cnt, 0);
    check(err == 1, "R6 err held while blocked", err, 1);
    check(int'(cur_mem) == m[0], "R6 memory unchanged while blocked", int'(cur_mem), m[0]);
    hold_targets();
    do_phase(1, 0, -1, 0, "R6 new raise clears err");
    // failed lower stops remaining lower steps, no blocking
    hold_targets();
    tgt_mem = 12'(m[0] - 5); l2_dig = 12'(m[1] - 5); tgt_ua = 12'(m[2] - 5); set_core_tgt(m[3] - 5, 0);
    do_phase(0, 0, 1, 0, "R6 lower nack on digital");
    do_phase(0, 0, -1, 0, "R6 lower after lower failure");

    // R10 vote merge
    for (int c = 0; c < 4; c++) vote(c, (c * 3 + 2) % 8);
    for (int mk = 0; mk < 16; mk++) begin
      @(negedge clk); present = 4'(mk);
      @(negedge clk); @(negedge clk);
      check_level("R10 present mask sweep");
    end
    present = 4'hF;
    for (int l = 0; l < 8; l++) vote(l % 4, l);
    for (int l = 7; l >= 0; l--) vote(2, l);
    present = 4'b0101;
    vote(1, 7);
    vote(0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule